// File: doc/BRIEF.md
# Clock Output Run/Stop Gating Controller

This block sits between a clock generator and the output pads of a multi-bank clock buffer. It receives one enable bit per output from a control register file, and four shared pins whose role is fixed by a mode strap. It also receives a global tristate bit. From these it produces a gated clock and a drive enable for every output. The output vector is laid out by bank: CPU, SDRAM, PCI, AGP and then fixed-frequency outputs. One CPU output can be exempted from the CPU stop.

The mode strap is captured once after reset. With the strap at 0, the four shared slots inside the SDRAM bank are ordinary clock outputs, and the shared pins are not used. With the strap at 1, those slots become inputs and the shared pins act as active-low stop requests. The stop requests pass through a two-flop synchronizer. Each output's clock is seen as a level sampled in the control clock domain. A gate may only open or close while that level is low, so no partial pulse ever leaves the block.

Top module: `clkgate_ctrl`

## Requirements
- R1: While reset is held, every `clk_out` bit and every `drv_en` bit is 0. The strap is captured on the first clock edge after reset release. Outputs run and drive from the second edge on.
- R2: With a 0 in `en_bits[i]`, output i is stopped. With a 1, it runs unless another condition stops it.
- R3: In mode 1, a low on `shr_n[3]` (CPU stop) stops CPU outputs 0 and 1.
- R4: CPU output 2 obeys the CPU stop only while `free_stoppable` is 1. While it is 0, that output keeps running under a CPU stop.
- R5: In mode 0, the shared SDRAM slots (vector bits 11 to 14) run as outputs and `shr_n` has no effect. In mode 1, those slots have `drv_en` and `clk_out` at 0, and `shr_is_input` is 1.
- R6: In mode 1, a low on `shr_n[1]` stops the non-shared SDRAM outputs (bits 3 to 10 and 15). A low on `shr_n[2]` stops the PCI outputs (bits 16 to 21).
- R7: In mode 1, a low on `shr_n[0]` (power-down) stops every output, including CPU output 2.
- R8: With `tristate` at 1, all `drv_en` bits go to 0 one edge later, while the gating state is kept.
- R9: The gate of output i changes only on an edge where `out_lvl[i]` is 0. `clk_out[i]` is `out_lvl[i]` AND that gate.
- R10: A stop request is synchronized through two flops. It takes effect on the third rising edge after it is applied, and not before.
- R11: A change on `strap_mode` after capture has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, faster than every output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 1 | Shared-pin personality strap |
| shr_n | input | 4 | Shared pins: [0] power-down, [1] SDRAM stop, [2] PCI stop, [3] CPU stop, all active low |
| en_bits | input | 26 | Per-output enable, 1 = active |
| free_stoppable | input | 1 | 1 lets the CPU stop halt CPU output 2 |
| tristate | input | 1 | 1 releases all outputs |
| out_lvl | input | 26 | Sampled level of each output's source clock |
| clk_out | output | 26 | Gated output clocks |
| drv_en | output | 26 | Per-output pad drive enable |
| shr_is_input | output | 1 | Captured mode, 1 = shared pins are inputs |

## Verification
The bench builds the block with its default bank sizes: three CPU, thirteen SDRAM with four shared slots from local index 8, six PCI, two AGP and two fixed outputs. With these sizes every stop class has members on both sides of a bank boundary, so a wrong mask offset shows up. The free-running CPU exception and both strap personalities can also be reached by resetting twice. The bench holds `out_lvl` high to freeze gates, and drives it low to let them move. This lets it tell the two-edge synchronizer delay and the low-phase rule apart from plain gating errors.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [2:0] {
        CLS_CPU,
        CLS_CPU_FREE,
        CLS_SDR,
        CLS_SDR_SHR,
        CLS_PCI,
        CLS_FIXED
    } out_cls_e;

    // Bank layout: CPU, SDRAM, PCI, then AGP and fixed-frequency outputs.
    function automatic out_cls_e class_of(input int i, input int n_cpu, input int free_cpu,
                                          input int n_sdr, input int shr_lo, input int n_pci);
        int k;
        if (i < n_cpu) return (i == free_cpu) ? CLS_CPU_FREE : CLS_CPU;
        if (i < n_cpu + n_sdr) begin
            k = i - n_cpu;
            return (k >= shr_lo && k < shr_lo + 4) ? CLS_SDR_SHR : CLS_SDR;
        end
        if (i < n_cpu + n_sdr + n_pci) return CLS_PCI;
        return CLS_FIXED;
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] sync_n
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_n;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: '1, s2: '1};
        else        st_q <= st_d;
    end

    assign sync_n = st_q.s2;

    // R10: second stage only ever takes the first stage's previous value
    a_r10_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic want,
    output logic run,
    output logic gclk
);
    logic run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!lvl) run_d = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign run  = run_q;
    assign gclk = lvl & run_q;

    // R9: gate is frozen while the source clock is high
    a_r9_low_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lvl) |-> $stable(run_q));
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_CPU    = 3,
    parameter int FREE_CPU = 2,
    parameter int N_SDR    = 13,
    parameter int SHR_LO   = 8,
    parameter int N_PCI    = 6,
    parameter int N_AGP    = 2,
    parameter int N_FIX    = 2,
    parameter int NOUT     = N_CPU + N_SDR + N_PCI + N_AGP + N_FIX
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_mode,
    input  logic [3:0]      shr_n,
    input  logic [NOUT-1:0] en_bits,
    input  logic            free_stoppable,
    input  logic            tristate,
    input  logic [NOUT-1:0] out_lvl,
    output logic [NOUT-1:0] clk_out,
    output logic [NOUT-1:0] drv_en,
    output logic            shr_is_input
);
    localparam int PD_B  = 0;
    localparam int SDS_B = 1;
    localparam int PCS_B = 2;
    localparam int CPS_B = 3;

    function automatic logic [NOUT-1:0] mask_of(input out_cls_e c);
        logic [NOUT-1:0] m;
        m = '0;
        for (int i = 0; i < NOUT; i++)
            m[i] = (class_of(i, N_CPU, FREE_CPU, N_SDR, SHR_LO, N_PCI) == c);
        return m;
    endfunction

    localparam logic [NOUT-1:0] M_CPU  = mask_of(CLS_CPU);
    localparam logic [NOUT-1:0] M_FREE = mask_of(CLS_CPU_FREE);
    localparam logic [NOUT-1:0] M_SDR  = mask_of(CLS_SDR);
    localparam logic [NOUT-1:0] M_SHR  = mask_of(CLS_SDR_SHR);
    localparam logic [NOUT-1:0] M_PCI  = mask_of(CLS_PCI);

    typedef struct packed {
        logic            latched;
        logic            mode;
        logic [NOUT-1:0] oe;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [3:0]      shr_s;
    logic [NOUT-1:0] want, run;
    logic            cpu_stop, sdr_stop, pci_stop, pd_act;

    clkgate_sync #(.W(4)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_n(shr_n),
        .sync_n (shr_s)
    );

    always_comb begin
        // stop pins count only when the strap made them inputs
        cpu_stop = st_q.mode & ~shr_s[CPS_B];
        sdr_stop = st_q.mode & ~shr_s[SDS_B];
        pci_stop = st_q.mode & ~shr_s[PCS_B];
        pd_act   = st_q.mode & ~shr_s[PD_B];

        want = {NOUT{st_q.latched}} & en_bits & ~(
                   (M_CPU  & {NOUT{cpu_stop}})
                 | (M_FREE & {NOUT{cpu_stop & free_stoppable}})
                 | (M_SDR  & {NOUT{sdr_stop}})
                 | (M_SHR  & {NOUT{st_q.mode}})
                 | (M_PCI  & {NOUT{pci_stop}})
                 | {NOUT{pd_act}});

        st_d = st_q;
        if (!st_q.latched) begin
            st_d.latched = 1'b1;
            st_d.mode    = strap_mode;
        end
        st_d.oe = (st_q.latched && !tristate) ? ~(M_SHR & {NOUT{st_q.mode}}) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{latched: 1'b0, mode: 1'b0, oe: '0};
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_cell
        clkgate_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (out_lvl[g]),
            .want (want[g]),
            .run  (run[g]),
            .gclk (clk_out[g])
        );

        a_r2_disabled_stops: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!en_bits[g] && !out_lvl[g]) |-> !run[g]);

        a_r7_powerdown_stops: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pd_act && !out_lvl[g]) |-> !run[g]);
    end

    assign drv_en       = st_q.oe;
    assign shr_is_input = st_q.mode;

    a_r4_free_runs: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.latched && !free_stoppable && !pd_act && en_bits[FREE_CPU] && !out_lvl[FREE_CPU])
        |-> run[FREE_CPU]);

    a_r8_tristate_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tristate) |-> (drv_en == '0));

    a_r5_shared_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        shr_is_input |-> ((drv_en & M_SHR) == '0));

    a_r11_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && $past(st_q.latched)) |-> $stable(st_q.mode));
endmodule

// File: tb/tb_clkgate_ctrl.sv
module tb_clkgate_ctrl;
    localparam int  NOUT   = 26;
    localparam time CLK_PD = 10;

    localparam logic [NOUT-1:0] ALL    = 26'h3FF_FFFF;
    localparam logic [NOUT-1:0] CPU01  = 26'h000_0003;
    localparam logic [NOUT-1:0] CPUALL = 26'h000_0007;
    localparam logic [NOUT-1:0] SHR    = 26'h000_7800;
    localparam logic [NOUT-1:0] SDRNS  = 26'h000_87F8;
    localparam logic [NOUT-1:0] PCI    = 26'h03F_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            strap_mode = 1'b0;
    logic [3:0]      shr_n = 4'hF;
    logic [NOUT-1:0] en_bits = ALL;
    logic            free_stoppable = 1'b1;
    logic            tristate = 1'b0;
    logic [NOUT-1:0] out_lvl = '0;
    logic [NOUT-1:0] clk_out, drv_en;
    logic            shr_is_input;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    clkgate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .shr_n(shr_n),
        .en_bits(en_bits), .free_stoppable(free_stoppable), .tristate(tristate),
        .out_lvl(out_lvl), .clk_out(clk_out), .drv_en(drv_en), .shr_is_input(shr_is_input)
    );

    always #(CLK_PD/2) clk = ~clk;

    task automatic chk(input string req, input logic [NOUT-1:0] act, input logic [NOUT-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // freeze gates by raising every source level, read, then lower again
    task automatic look(output logic [NOUT-1:0] c);
        out_lvl = '1;
        #1;
        c = clk_out;
        out_lvl = '0;
    endtask

    task automatic do_reset(input logic strap);
        logic [NOUT-1:0] c;
        @(negedge clk);
        rst_n = 1'b0; strap_mode = strap; shr_n = 4'hF; en_bits = ALL;
        free_stoppable = 1'b1; tristate = 1'b0; out_lvl = '0;
        edges(3);
        look(c);
        chk("R1 reset clk_out", c, '0);
        chk("R1 reset drv_en", drv_en, '0);
        rst_n = 1'b1;
        edges(3);
    endtask

    task automatic t_mode0_run();
        logic [NOUT-1:0] c;
        do_reset(1'b0);
        look(c);
        chk("R1 all running", c, ALL);
        chk("R1 all driven", drv_en, ALL);
        chk("R5 mode0 output", {25'd0, shr_is_input}, '0);
    endtask

    task automatic t_enable();
        logic [NOUT-1:0] c;
        en_bits = ALL & ~(26'h1 << 5) & ~(26'h1 << 17);
        edges(1);
        look(c);
        chk("R2 disabled outputs stop", c, ALL & ~(26'h1 << 5) & ~(26'h1 << 17));
        en_bits = ALL;
        edges(1);
        look(c);
        chk("R2 re-enabled", c, ALL);
    endtask

    task automatic t_shared_ignored();
        logic [NOUT-1:0] c;
        shr_n = 4'h0;
        edges(4);
        look(c);
        chk("R5 mode0 pins ignored", c, ALL);
        shr_n = 4'hF;
    endtask

    task automatic t_mode1();
        logic [NOUT-1:0] c;
        do_reset(1'b1);
        look(c);
        chk("R5 shared slots stopped", c, ALL & ~SHR);
        chk("R5 shared slots undriven", drv_en, ALL & ~SHR);
        chk("R5 shr_is_input", {25'd0, shr_is_input}, 26'd1);
    endtask

    task automatic t_cpu_stop();
        logic [NOUT-1:0] c;
        free_stoppable = 1'b1;
        shr_n[3] = 1'b0;
        edges(2);
        look(c);
        chk("R10 not yet after two edges", c, ALL & ~SHR);
        edges(1);
        look(c);
        chk("R3 cpu stop with free bit stoppable", c, ALL & ~SHR & ~CPUALL);
        free_stoppable = 1'b0;
        edges(1);
        look(c);
        chk("R4 free cpu output runs", c, ALL & ~SHR & ~CPU01);
        shr_n[3] = 1'b1;
        free_stoppable = 1'b1;
        edges(3);
        look(c);
        chk("R3 cpu stop released", c, ALL & ~SHR);
    endtask

    task automatic t_sdr_pci();
        logic [NOUT-1:0] c;
        shr_n[1] = 1'b0;
        edges(3);
        look(c);
        chk("R6 sdram stop", c, ALL & ~SHR & ~SDRNS);
        shr_n[1] = 1'b1;
        shr_n[2] = 1'b0;
        edges(3);
        look(c);
        chk("R6 pci stop", c, ALL & ~SHR & ~PCI);
        shr_n[2] = 1'b1;
        edges(3);
    endtask

    task automatic t_pd();
        logic [NOUT-1:0] c;
        free_stoppable = 1'b0;
        shr_n[0] = 1'b0;
        edges(3);
        look(c);
        chk("R7 power-down stops all", c, '0);
        shr_n[0] = 1'b1;
        free_stoppable = 1'b1;
        edges(3);
        look(c);
        chk("R7 power-down released", c, ALL & ~SHR);
    endtask

    task automatic t_tristate();
        logic [NOUT-1:0] c;
        tristate = 1'b1;
        edges(1);
        chk("R8 drive released", drv_en, '0);
        look(c);
        chk("R8 gating kept", c, ALL & ~SHR);
        tristate = 1'b0;
        edges(1);
        chk("R8 drive restored", drv_en, ALL & ~SHR);
    endtask

    task automatic t_low_phase();
        logic [NOUT-1:0] c;
        out_lvl = '1;
        en_bits[20] = 1'b0;
        edges(3);
        chk("R9 gate held while high", clk_out, ALL & ~SHR);
        out_lvl = '0;
        edges(1);
        look(c);
        chk("R9 gate moves when low", c, ALL & ~SHR & ~(26'h1 << 20));
        en_bits = ALL;
        edges(1);
    endtask

    task automatic t_strap_hold();
        strap_mode = 1'b0;
        edges(4);
        chk("R11 strap held", {25'd0, shr_is_input}, 26'd1);
    endtask

    initial begin
        t_mode0_run();
        t_enable();
        t_shared_ignored();
        t_mode1();
        t_cpu_stop();
        t_sdr_pci();
        t_pd();
        t_tristate();
        t_low_phase();
        t_strap_hold();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule